// File: doc/BRIEF.md
# Serial Port Bit-Clock Prescaler

This block derives the internal bit clock of a synchronous serial port from the core clock. A chain of three dividers does the work. The first is a fixed divide-by-eight stage that a range bit can bypass. The second is an 8-bit modulus divider that divides by the programmed modulus plus one. The last is a toggle stage that gives a bit clock with a 50% duty cycle. A 24-bit control register holds the modulus and the range bit, and a simple write strobe with a combinational read path gives access to it.

The bit-clock level can be routed to the transmit-clock and receive-clock outputs of the port. The shift registers stay in the core clock domain and use the single-cycle rising-edge and falling-edge strobes. A new setting is held aside until the divider chain reaches its next terminal count, so a write never shortens or stretches the half period already in progress. A synchronous soft reset clears the same state as the asynchronous hardware reset.

Top module: `serclk_divider`

## Requirements
- R1: A write stores control bits 7..0 as the modulus M and bit 11 as the range bit B, and the read port returns them in those same positions.
- R2: Control bits 23..12 and 10..8 always read as 0, and a write to them has no effect on the register or on the bit-clock period.
- R3: After hardware reset the read port, the bit clock and both strobes are 0, and the first bit-clock period is 16 core clocks.
- R4: With B=0 the bit-clock period is 2*(M+1)*8 core clocks.
- R5: With B=1 the fixed stage is bypassed and the period is 2*(M+1) core clocks.
- R6: The setting M=0 with B=1 would give a ratio below 4, so it is clamped to a period of 4 core clocks.
- R7: The bit clock spends exactly half of each period high and half low.
- R8: The rise strobe is high for one core clock in the same cycle the bit clock goes from 0 to 1. The fall strobe does the same when it goes from 1 to 0.
- R9: A written setting takes effect only at the next terminal count, so the half period in progress ends with the old timing.
- R10: A soft reset clears the register, the bit clock and the divider counters, and the chain then restarts with a 16-clock period.
- R11: The period is never below 4 and never above 4096 core clocks, and M=0xFF with B=0 gives exactly 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 24 | Control register write data |
| cfg_rdata | output | 24 | Control register read data |
| bclk | output | 1 | Bit-clock level |
| bclk_rise | output | 1 | One-cycle strobe when the bit clock rises |
| bclk_fall | output | 1 | One-cycle strobe when the bit clock falls |

## Verification
The hardest case to reach is a write that lands part way through a half period, because its effect must be held back until the terminal count. The bench places a write a fixed number of cycles after a rise strobe, with a slow setting in effect. It then checks that the pending high phase keeps the old length and that the phase after it already has the clamped fast length. A behavioural model of the period and phase also follows every cycle, so writes that coincide with a terminal count are covered as the sweeps go through the extreme moduli of both ranges.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  localparam int REG_W     = 24;
  localparam int MOD_W     = 8;
  localparam int RANGE_BIT = 11;
  localparam int FIXED_DIV = 8;

  typedef struct packed {
    logic             bypass;
    logic [MOD_W-1:0] modulus;
  } div_cfg_t;

  // Modulus actually used by the variable stage: clamps ratio to >= 4
  function automatic logic [MOD_W-1:0] eff_modulus(div_cfg_t c);
    if (c.bypass && (c.modulus == '0)) return MOD_W'(1);
    return c.modulus;
  endfunction

  function automatic logic [REG_W-1:0] pack_reg(div_cfg_t c);
    logic [REG_W-1:0] r;
    r = '0;
    r[RANGE_BIT]   = c.bypass;
    r[MOD_W-1:0]   = c.modulus;
    return r;
  endfunction

  function automatic div_cfg_t unpack_reg(logic [REG_W-1:0] r);
    div_cfg_t c;
    c.bypass  = r[RANGE_BIT];
    c.modulus = r[MOD_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/serclk_cfg_reg.sv
module serclk_cfg_reg
  import serclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output div_cfg_t         prog_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prog_cfg <= '0;
    else if (soft_rst) prog_cfg <= '0;
    else if (wr_en)    prog_cfg <= unpack_reg(wdata);
  end

  assign rdata = pack_reg(prog_cfg);
endmodule

// File: rtl/serclk_fixed_stage.sv
module serclk_fixed_stage #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bypass,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = bypass | (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr || bypass)         cnt <= '0;
    else if (cnt == LAST)           cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serclk_var_stage.sv
module serclk_var_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         term
);
  logic [W-1:0] cnt;

  assign term = tick && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || term)  cnt <= '0;
    else if (tick)         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/serclk_toggle.sv
module serclk_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic term,
  output logic bclk,
  output logic rise_stb,
  output logic fall_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk <= 1'b0; rise_stb <= 1'b0; fall_stb <= 1'b0;
    end else if (clr) begin
      bclk <= 1'b0; rise_stb <= 1'b0; fall_stb <= 1'b0;
    end else begin
      bclk     <= bclk ^ term;
      rise_stb <= term & ~bclk;
      fall_stb <= term &  bclk;
    end
  end
endmodule

// File: rtl/serclk_divider.sv
module serclk_divider
  import serclk_pkg::*;
#(
  parameter int FIX_DIV = FIXED_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             bclk,
  output logic             bclk_rise,
  output logic             bclk_fall
);
  div_cfg_t         prog_cfg;   // as written
  div_cfg_t         act_cfg;    // as used by the chain
  logic             fix_tick;
  logic             term_evt;   // terminal count of the whole chain
  logic [MOD_W-1:0] var_limit;

  serclk_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .wr_en(cfg_wr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .prog_cfg(prog_cfg)
  );

  // Pending setting is applied only at a terminal count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act_cfg <= '0;
    else if (soft_rst) act_cfg <= '0;
    else if (term_evt) act_cfg <= prog_cfg;
  end

  assign var_limit = eff_modulus(act_cfg);

  serclk_fixed_stage #(.DIV(FIX_DIV)) u_fix (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst | term_evt),
    .bypass(act_cfg.bypass), .tick(fix_tick)
  );

  serclk_var_stage #(.W(MOD_W)) u_var (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .tick(fix_tick), .limit(var_limit), .term(term_evt)
  );

  serclk_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .term(term_evt),
    .bclk(bclk), .rise_stb(bclk_rise), .fall_stb(bclk_fall)
  );
endmodule

// File: rtl/serclk_checker.sv
module serclk_checker
  import serclk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             cfg_wr,
  input logic [MOD_W-1:0] wr_mod,
  input logic             wr_range,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             bclk,
  input logic             bclk_rise,
  input logic             bclk_fall,
  input logic             term_evt,
  input div_cfg_t         act_cfg
);
  logic        bclk_q;
  logic [11:0] half_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0; half_cnt <= '0;
    end else begin
      bclk_q <= bclk;
      if (bclk != bclk_q)        half_cnt <= '0;
      else if (half_cnt != '1)   half_cnt <= half_cnt + 1'b1;
    end
  end

  assert_wr_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !soft_rst) |=> (cfg_rdata[MOD_W-1:0] == $past(wr_mod)) &&
                              (cfg_rdata[RANGE_BIT] == $past(wr_range)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[23:12] == '0) && (cfg_rdata[10:8] == '0));

  assert_rise_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |-> (bclk && !$past(bclk)));

  assert_fall_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |-> (!bclk && $past(bclk)));

  assert_hold_setting_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!term_evt && !soft_rst) |=> $stable(act_cfg));

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((cfg_rdata == '0) && !bclk));

  assert_min_half_R6: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ((bclk != bclk_q) && !$past(soft_rst)) |-> (half_cnt >= 12'd1));

  assert_max_half_R11: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ((bclk != bclk_q) && !$past(soft_rst)) |-> (half_cnt <= 12'd2047));
endmodule

bind serclk_divider serclk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
  .wr_mod(cfg_wdata[7:0]), .wr_range(cfg_wdata[11]),
  .cfg_rdata(cfg_rdata), .bclk(bclk), .bclk_rise(bclk_rise),
  .bclk_fall(bclk_fall), .term_evt(term_evt), .act_cfg(act_cfg)
);

// File: tb/sim_serclk_divider.sv
`timescale 1ns/1ps
module sim_serclk_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [23:0] cfg_wdata = '0;
  logic [23:0] cfg_rdata;
  logic        bclk, bclk_rise, bclk_fall;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  serclk_divider u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bclk(bclk),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Half period in core clocks, restated from R4..R6
  function automatic int half_of(logic [23:0] r);
    int h;
    h = (int'(r[7:0]) + 1) * (r[11] ? 1 : 8);
    if (h < 2) h = 2;
    return h;
  endfunction

  // Behavioural reference, advanced on every clock
  logic [23:0] m_reg;
  int          m_half, m_cnt;
  bit          m_bclk, m_rise, m_fall;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      m_reg = '0; m_half = 8; m_cnt = 0;
      m_bclk = 0; m_rise = 0; m_fall = 0;
    end else begin
      m_rise = 0; m_fall = 0;
      m_cnt++;
      if (m_cnt == m_half) begin
        m_cnt  = 0;
        m_bclk = !m_bclk;
        if (m_bclk) m_rise = 1; else m_fall = 1;
        m_half = half_of(m_reg);
      end
      if (cfg_wr) m_reg = cfg_wdata & 24'h0008FF;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4/R7 bclk vs model", int'(bclk), int'(m_bclk));
      chk("R8 rise strobe vs model", int'(bclk_rise), int'(m_rise));
      chk("R8 fall strobe vs model", int'(bclk_fall), int'(m_fall));
      chk("R1/R2 readback vs model", int'(cfg_rdata), int'(m_reg));
    end
  end

  task automatic wr(logic [23:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!bclk_rise);
  endtask

  task automatic measure_now(int exp_per, string tag);
    int hi, per;
    wait_rise();
    hi = 0;
    do begin @(negedge clk); hi++; end while (!bclk_fall);
    per = hi;
    do begin @(negedge clk); per++; end while (!bclk_rise);
    chk({tag, " period"}, per, exp_per);
    chk({"R7 high time ", tag}, hi, exp_per / 2);
  endtask

  task automatic measure(logic [23:0] w, int exp_per, string tag);
    wr(w);
    wait_rise();
    measure_now(exp_per, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo;
    // R3: reset state
    repeat (3) @(negedge clk);
    chk("R3 rdata in reset", int'(cfg_rdata), 0);
    chk("R3 bclk in reset", int'(bclk), 0);
    chk("R3 strobes in reset", int'({bclk_rise, bclk_fall}), 0);
    rst_n = 1'b1;
    measure_now(16, "R3 first");

    // R4 fixed stage active
    measure(24'h000000, 16,   "R4 M=00");
    measure(24'h000001, 32,   "R4 M=01");
    measure(24'h00007F, 2048, "R4 M=7F");
    measure(24'h0000FF, 4096, "R11 R4 M=FF slowest");
    // R5 fixed stage bypassed, R6 clamp
    measure(24'h000800, 4,    "R6 clamp M=00");
    measure(24'h000801, 4,    "R11 R5 M=01 fastest");
    measure(24'h00087F, 256,  "R5 M=7F");
    // R2: reserved bits set on write
    measure(24'hFFFFFF, 512,  "R2 R5 M=FF");
    chk("R2 readback of all-ones", int'(cfg_rdata), 24'h0008FF);
    measure(24'hFFF700, 16,   "R2 reserved-only");
    chk("R2 readback reserved-only", int'(cfg_rdata), 0);
    chk("R1 readback", int'(cfg_rdata[7:0]), 0);

    // R9: write mid half-period
    measure(24'h000003, 64, "R4 M=03");
    wait_rise();
    hi = 0;
    do begin
      @(negedge clk); hi++;
      if (hi == 5) begin cfg_wr = 1'b1; cfg_wdata = 24'h000800; end
      else cfg_wr = 1'b0;
    end while (!bclk_fall);
    cfg_wr = 1'b0;
    chk("R9 pending half keeps old timing", hi, 32);
    lo = 0;
    do begin @(negedge clk); lo++; end while (!bclk_rise);
    chk("R9 next half uses new timing", lo, 2);
    chk("R1 readback after mid write", int'(cfg_rdata), 24'h000800);

    // R10: soft reset
    wr(24'h0000FF);
    repeat (10) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk("R10 rdata after soft reset", int'(cfg_rdata), 0);
    chk("R10 bclk after soft reset", int'(bclk), 0);
    measure_now(16, "R10 restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule